// File: doc/BRIEF.md
# Dual Prescaler Clock Divider

This block turns a single system clock into one tick-enable strobe per channel for a five-channel PWM timer. Two 8-bit prescalers each divide the system clock by their programmed value plus one. The low channels share the first prescaler and the remaining channels share the second. Behind the prescalers, each channel has its own selector. The selector either applies a power-of-two post-division to its prescaler's output or passes through an external tick. That external tick arrives as an already synchronised one-cycle pulse, and it is shared by the same channel group.

Software sets up the block through a narrow write port that reaches two configuration words. One word holds both prescaler values. The other packs one 4-bit selector code per channel. Each tick output is a strobe that the downstream counter logic uses as its clock enable. Any configuration write restarts the affected counters, so the first tick after a change always comes a known number of cycles after that change.

Top module: `pwm_tick_divider`

## Requirements
- R1: While reset is asserted every tick output is low. All prescaler values and selector codes reset to zero, so after reset each channel ticks every 2 cycles (prescale 0, code 0, post-division base 1).
- R2: In the prescale word (`wr_sel` = 0), bits [7:0] set prescaler A and bits [15:8] set prescaler B. Channels 0 and 1 use prescaler A; channels 2, 3 and 4 use prescaler B.
- R3: A prescale value p divides the system clock by p+1 for every value from 0 to 255.
- R4: In the selector word (`wr_sel` = 1), channel c's code sits in bits [4c+3:4c].
- R5: A selector code n that is not an external code gives a tick period of (p+1)·2^(n+1) system cycles, where the post-division base defaults to 1.
- R6: Selector code 4 (the default external-code mask) makes the channel output the external tick of its group, delayed by one cycle.
- R7: Channels 0 and 1 follow `ext_tick[0]`; channels 2, 3 and 4 follow `ext_tick[1]`.
- R8: A write to the prescale word restarts both prescalers and all post-dividers. A write to the selector word restarts all post-dividers. Every tick is low in the cycle after any write. For a divided channel, the first tick comes exactly one period after the write edge, and ticks repeat every period after that.
- R9: A divided channel whose period exceeds one cycle is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | Word select: 0 prescale word, 1 selector word |
| wr_data | input | 32 | Write data |
| ext_tick | input | 2 | Synchronised external tick pulses, one per channel group |
| tick_o | output | 5 | Per-channel one-cycle tick enables |

## Verification
The assertions assume several things about the inputs. A prescale value changes only through a write, and that write restarts its counter at the same edge. A selector code changes only through a selector or prescale write. External ticks are sampled in the cycle they are presented. The stimulus writes configuration only through the port. It holds `ext_tick` low during every write cycle and drives it with random values between writes. Each observation window is counted from the write that restarted the counters. When only the selector word is written, the prescale values are first set to zero, so the prescaler phase is known.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

  typedef enum logic {
    SEL_PRESCALE = 1'b0,
    SEL_MUX      = 1'b1
  } cfg_sel_e;

  function automatic int unsigned group_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

endpackage

// File: rtl/ptd_prescaler.sv
module ptd_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             pulse
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    pulse = (cnt_q == limit);
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (pulse) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: the counter never passes the programmed value
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R9: with a division above one the prescaler pulse is isolated
  a_r9_pre_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !restart && limit != '0) |=> !pulse);

endmodule

// File: rtl/ptd_chan_div.sv
module ptd_chan_div #(
  parameter int                SEL_W    = 4,
  parameter int                DIV_BASE = 1,
  parameter logic [2**SEL_W-1:0] EXT_MASK = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             base_pulse,
  input  logic             ext_pulse,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);

  localparam int MAX_SHIFT = (2**SEL_W) - 1 + DIV_BASE;
  localparam int DCW       = MAX_SHIFT + 1;
  localparam int SHW       = $clog2(MAX_SHIFT + 1);

  logic           ext_mode;
  logic [SHW-1:0] shift;
  logic [DCW-1:0] target;
  logic           hit;
  logic [DCW-1:0] dcnt_q;
  logic [DCW-1:0] dcnt_d;
  logic           tick_q;
  logic           tick_d;

  always_comb begin
    ext_mode = EXT_MASK[code];
    shift    = SHW'(code) + SHW'(DIV_BASE);
    target   = (DCW'(1) << shift) - DCW'(1);
    hit      = base_pulse && (dcnt_q == target);
    dcnt_d   = dcnt_q;
    if (restart) begin
      dcnt_d = '0;
    end else if (!ext_mode && base_pulse) begin
      dcnt_d = hit ? '0 : dcnt_q + 1'b1;
    end
    if (restart) begin
      tick_d = 1'b0;
    end else if (ext_mode) begin
      tick_d = ext_pulse;
    end else begin
      tick_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R8: a restart silences the channel for one cycle
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R5: post-divider count stays within the selected power of two
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= target);

  // R6: in external mode the output follows the external pulse one cycle later
  a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !restart) |=> (tick == $past(ext_pulse)));

endmodule

// File: rtl/pwm_tick_divider.sv
module pwm_tick_divider #(
  parameter int                NUM_CH   = 5,
  parameter int                PRE_W    = 8,
  parameter int                SEL_W    = 4,
  parameter int                DIV_BASE = 1,
  parameter logic [2**SEL_W-1:0] EXT_MASK = 16'h0010,
  parameter int                GRP0_CH  = 2,
  parameter int                DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        ext_tick,
  output logic [NUM_CH-1:0] tick_o
);

  import ptd_pkg::*;

  localparam int MUX_W = NUM_CH * SEL_W;

  logic rst_meta_q;
  logic rst_sync_q;
  logic rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_n_int = rst_sync_q;

  logic [PRE_W-1:0] pre_q [2];
  logic [PRE_W-1:0] pre_d [2];
  logic [MUX_W-1:0] mux_q;
  logic [MUX_W-1:0] mux_d;
  logic             wr_pre;
  logic             wr_mux;
  logic             restart_pre;
  logic             restart_div;

  always_comb begin
    wr_pre      = wr_en && (cfg_sel_e'(wr_sel) == SEL_PRESCALE);
    wr_mux      = wr_en && (cfg_sel_e'(wr_sel) == SEL_MUX);
    restart_pre = wr_pre;
    restart_div = wr_pre || wr_mux;
    pre_d[0]    = pre_q[0];
    pre_d[1]    = pre_q[1];
    mux_d       = mux_q;
    if (wr_pre) begin
      pre_d[0] = wr_data[PRE_W-1:0];
      pre_d[1] = wr_data[2*PRE_W-1:PRE_W];
    end
    if (wr_mux) begin
      mux_d = wr_data[MUX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pre_q[0] <= '0;
      pre_q[1] <= '0;
      mux_q    <= '0;
    end else begin
      pre_q[0] <= pre_d[0];
      pre_q[1] <= pre_d[1];
      mux_q    <= mux_d;
    end
  end

  logic [1:0] pre_pulse;

  for (genvar g = 0; g < 2; g++) begin : g_pre
    ptd_prescaler #(
      .PRE_W (PRE_W)
    ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .restart (restart_pre),
      .limit   (pre_q[g]),
      .pulse   (pre_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = group_of(c, GRP0_CH);
    ptd_chan_div #(
      .SEL_W    (SEL_W),
      .DIV_BASE (DIV_BASE),
      .EXT_MASK (EXT_MASK)
    ) u_div (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .restart    (restart_div),
      .base_pulse (pre_pulse[GRP]),
      .ext_pulse  (ext_tick[GRP]),
      .code       (mux_q[c*SEL_W +: SEL_W]),
      .tick       (tick_o[c])
    );
  end

  // R1: nothing ticks while the internal reset is held
  always @(posedge clk) begin
    if (!rst_n_int) begin
      a_r1_reset_quiet: assert (tick_o == '0);
    end
  end

  // R8: a prescale write is followed by a silent cycle on every channel
  a_r8_write_silence: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_pre |=> (tick_o == '0));

  // R2: a selector write leaves the prescale word untouched
  a_r2_pre_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_mux) |=> ($stable(pre_q[0]) && $stable(pre_q[1])));

endmodule

// File: tb/pwm_tick_divider_bench.sv
module pwm_tick_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ext_tick = '0;
  logic [4:0]  tick_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwm_tick_divider u_pwm_tick_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ext_tick (ext_tick),
    .tick_o   (tick_o)
  );

  function automatic int grp(input int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  function automatic bit is_ext(input logic [3:0] code);
    return code == 4'd4;
  endfunction

  function automatic int period(input logic [7:0] p, input logic [3:0] code);
    return (int'(p) + 1) << (int'(code) + 1);
  endfunction

  task automatic check(input string tag, input int ch, input int cyc, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s ch%0d cycle %0d: got %0b expected %0b", tag, ch, cyc, got, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; ext_tick = 2'b00;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // window counted from the restarting write edge
  task automatic run_window(input string tag, input int w, input logic [7:0] p0,
                            input logic [7:0] p1, input logic [19:0] mux, input bit rand_ext);
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        logic [3:0] code;
        logic [7:0] p;
        logic       exp;
        code = mux[c*4 +: 4];
        p    = (grp(c) == 0) ? p0 : p1;
        if (is_ext(code)) begin
          exp = ext_tick[grp(c)];
          check((c < 2) ? "R6" : "R7", c, i, tick_o[c], exp);
        end else begin
          exp = ((i % period(p, code)) == 0);
          check(tag, c, i, tick_o[c], exp);
        end
      end
      ext_tick = rand_ext ? 2'($urandom_range(0, 3)) : 2'b00;
    end
    ext_tick = 2'b00;
  endtask

  task automatic trial(input string tag, input logic [7:0] p0, input logic [7:0] p1,
                       input logic [19:0] mux, input int w);
    cfg_write(1'b1, {12'd0, mux});
    cfg_write(1'b0, {16'd0, p1, p0});
    run_window(tag, w, p0, p1, mux, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd20240611));
    // R1: quiet during reset
    repeat (4) begin
      @(negedge clk);
      check("R1", 0, 0, |tick_o, 1'b0);
    end
    rst_n = 1'b1;
    // R1: reset prescale/code give a 2-cycle period
    first = 0;
    for (int k = 0; k < 20 && first == 0; k++) begin
      @(negedge clk);
      if (tick_o[0]) first = 1;
    end
    check("R1", 0, 0, first[0], 1'b1);
    @(negedge clk); check("R1", 0, 1, tick_o[0], 1'b0);
    @(negedge clk); check("R1", 0, 2, tick_o[0], 1'b1);
    // R1: selector reset value seen after a zero prescale write
    cfg_write(1'b0, 32'd0);
    run_window("R1", 12, 8'd0, 8'd0, 20'd0, 1'b0);

    // R2: prescaler A for ch0-1, B for ch2-4
    trial("R2", 8'd1, 8'd3, 20'd0, 40);
    // R4: field positions per channel
    trial("R4", 8'd0, 8'd0, {4'd0, 4'd3, 4'd2, 4'd1, 4'd0}, 70);
    // R3: extreme prescale values
    trial("R3", 8'd255, 8'd254, 20'd0, 1100);
    // R5: codes and prescale combined
    trial("R5", 8'd2, 8'd0, {4'd3, 4'd2, 4'd1, 4'd3, 4'd2}, 120);
    // R6: external selection on one channel per group
    trial("R6", 8'd1, 8'd1, {4'd0, 4'd4, 4'd0, 4'd0, 4'd4}, 60);
    // R8: selector-only write restarts post-dividers (prescalers at zero)
    cfg_write(1'b0, 32'd0);
    repeat (7) @(negedge clk);
    cfg_write(1'b1, {12'd0, 4'd2, 4'd0, 4'd1, 4'd3, 4'd2});
    run_window("R8", 50, 8'd0, 8'd0, {4'd2, 4'd0, 4'd1, 4'd3, 4'd2}, 1'b0);

    // R9: random configurations
    for (int t = 0; t < 25; t++) begin
      logic [7:0]  p0, p1;
      logic [19:0] mux;
      int          dmax;
      p0 = 8'($urandom_range(0, 15));
      p1 = 8'($urandom_range(0, 15));
      dmax = 1;
      for (int c = 0; c < 5; c++) begin
        logic [3:0] code;
        code = 4'($urandom_range(0, 4));
        mux[c*4 +: 4] = code;
        if (!is_ext(code) && period((grp(c) == 0) ? p0 : p1, code) > dmax)
          dmax = period((grp(c) == 0) ? p0 : p1, code);
      end
      trial("R9", p0, p1, mux, 3 * dmax + 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule